// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Slave with Change Interrupt

This block is a two-wire serial slave that serves one eight-bit quasi-bidirectional port. It has no direction register. A pin is driven low by writing a 0 to its latch bit. A pin written with a 1 is left to a weak pull-up, so it can act as an input. A master addresses the block with a leading 0 followed by six strap pins. Every data byte in a write transaction is moved to the port latch in turn. A read transaction samples the pins and shifts their states out for as long as the master acknowledges.

The block runs from a system clock that oversamples the bus. It takes SCL and SDA levels that are already synchronised, and it detects START, STOP and clock edges internally. An active-low interrupt output reports that the pins differ from a reference snapshot. An access to the port clears the interrupt, and so does the pins returning to their snapshot values. When the interrupt is cleared by an access, the snapshot is reloaded from the pins one clock later. That delay lets a pin just driven by a write settle before it is captured. A pin written from 0 to 1 gets a one-shot strong pull-up enable, which lasts until the next falling SCL edge.

Top module: `qport_i2c_slave`

## Requirements
- R1: After reset the port latch is all ones, every strong pull-up enable is off, the interrupt output is high (inactive) and SDA is released.
- R2: The block acknowledges an address byte whose bits 7..1 equal {0, strap[5:0]} by pulling SDA low for the ninth clock. Bit 0 of that byte selects read (1) or write (0). Any other address byte, including one with a leading 1, gets no acknowledge, and the block ignores the rest of that transaction.
- R3: In a write, each data byte is acknowledged. The byte is loaded into the port latch at the falling SCL edge that ends its acknowledge clock. Successive bytes in one transaction update the latch one after another.
- R4: When a write loads the latch, each bit that goes from 0 to 1 turns on that pin's strong pull-up enable. All enables turn off at the next falling SCL edge.
- R5: In a read, the pins are sampled at the rising SCL edge of the acknowledge clock that comes before each data byte, and the byte is sent most significant bit first. A master acknowledge (SDA low) starts another byte. A master not-acknowledge makes the block release SDA and go idle.
- R6: The interrupt output goes low within two clocks once the pins differ from the snapshot. It returns high if the pins go back to the snapshot values.
- R7: In a read addressed to this block, the interrupt is cleared and the snapshot is reloaded at the rising SCL edge of the address acknowledge clock, and again at each master acknowledge.
- R8: In a write addressed to this block, the interrupt is cleared and the snapshot is reloaded at the falling SCL edge that ends each data acknowledge.
- R9: A transaction to any other address leaves the interrupt, the snapshot and the port latch unchanged.
- R10: A START in the middle of a byte abandons the transfer and restarts address reception. After a STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (wired bus value) |
| strap_i | input | 6 | Hardware address strap pins |
| pin_i | input | 8 | Present logic levels of the port pins |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| latch_o | output | 8 | Port latch; 0 drives the pin low, 1 leaves it weakly high |
| boost_o | output | 8 | One-shot strong pull-up enable per pin |
| int_n_o | output | 1 | Active-low change interrupt (open-drain level) |

## Verification
A corrupted snapshot register does not stay hidden: it shows on the interrupt output two clocks after the next pin change, or right after the next port access when the reload misses. A transfer state machine stuck in the wrong phase shows up on SDA within one bit time. It appears as a missing or extra acknowledge, a data bit driven in an acknowledge slot, or SDA held through a STOP. A wrong shift or bit count shows up as a wrong latch value after the acknowledge clock of a write, or as a wrong bit in the byte a read returns. A strong pull-up enable that is left on stays visible past the next falling SCL edge.

// File: rtl/qport_pkg.sv
package qport_pkg;

    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 6;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_AACK,
        LS_WDATA,
        LS_WACK,
        LS_RDATA,
        LS_RACK
    } link_st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    // Address byte layout: bit 7 fixed 0, bits 6..1 strap, bit 0 direction.
    function automatic logic addr_hit(input logic [BYTE_W-1:0] abyte,
                                      input logic [STRAP_W-1:0] strap);
        return abyte[BYTE_W-1:1] == {1'b0, strap};
    endfunction

    function automatic logic [BYTE_W-1:0] rising_bits(input logic [BYTE_W-1:0] old_v,
                                                      input logic [BYTE_W-1:0] new_v);
        return new_v & ~old_v;
    endfunction

endpackage

// File: rtl/qport_busevt.sv
module qport_busevt
    import qport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.start = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop  = scl_i & scl_q & ~sda_q & sda_i;
        evt.rise  = scl_i & ~scl_q;
        evt.fall  = ~scl_i & scl_q;
    end
endmodule

// File: rtl/qport_link.sv
module qport_link
    import qport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  pin_i,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               rd_clr,
    output logic               sda_pull_o
);
    link_st_t          st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw;
    logic              more;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LS_IDLE;
            cnt  <= '0;
            sh   <= '0;
            rw   <= 1'b0;
            more <= 1'b0;
        end else if (evt.start) begin
            st  <= LS_ADDR;
            cnt <= '0;
        end else if (evt.stop) begin
            st <= LS_IDLE;
        end else begin
            unique case (st)
                LS_ADDR, LS_WDATA: begin
                    if (evt.rise && cnt != FULL) begin
                        sh  <= {sh[BYTE_W-2:0], sda_i};
                        cnt <= cnt + 1'b1;
                    end
                    if (evt.fall && cnt == FULL) begin
                        if (st == LS_WDATA) begin
                            st <= LS_WACK;
                        end else if (addr_hit(sh, strap_i)) begin
                            st <= LS_AACK;
                            rw <= sh[0];
                        end else begin
                            st <= LS_IDLE;
                        end
                    end
                end
                LS_AACK: begin
                    if (evt.rise && rw) sh <= pin_i;
                    if (evt.fall) begin
                        cnt <= '0;
                        st  <= rw ? LS_RDATA : LS_WDATA;
                    end
                end
                LS_WACK: begin
                    if (evt.fall) begin
                        cnt <= '0;
                        st  <= LS_WDATA;
                    end
                end
                LS_RDATA: begin
                    if (evt.fall) begin
                        if (cnt == LAST) begin
                            st <= LS_RACK;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                LS_RACK: begin
                    if (evt.rise) begin
                        more <= ~sda_i;
                        if (!sda_i) sh <= pin_i;
                    end
                    if (evt.fall) begin
                        cnt <= '0;
                        st  <= more ? LS_RDATA : LS_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_stb     = (st == LS_WACK) && evt.fall && !evt.start && !evt.stop;
        wr_data    = sh;
        rd_clr     = evt.rise && ((st == LS_AACK && rw) || (st == LS_RACK && !sda_i));
        sda_pull_o = (st == LS_AACK) || (st == LS_WACK) || (st == LS_RDATA && !sh[BYTE_W-1]);
    end
endmodule

// File: rtl/qport_pins.sv
module qport_pins
    import qport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_clr,
    input  logic              scl_fall,
    input  logic [BYTE_W-1:0] pin_i,
    output logic [BYTE_W-1:0] latch_o,
    output logic [BYTE_W-1:0] boost_o,
    output logic              int_n_o
);
    logic [BYTE_W-1:0] snap;
    logic              resnap;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_o <= '1;
            boost_o <= '0;
        end else if (wr_stb) begin
            latch_o <= wr_data;
            boost_o <= rising_bits(latch_o, wr_data);
        end else if (scl_fall) begin
            boost_o <= '0;
        end
    end

    // Snapshot reload is deferred one clock so freshly driven pins settle.
    always_ff @(posedge clk) begin
        if (rst) begin
            snap    <= '1;
            resnap  <= 1'b0;
            int_n_o <= 1'b1;
        end else if (wr_stb || rd_clr) begin
            resnap  <= 1'b1;
            int_n_o <= 1'b1;
        end else if (resnap) begin
            snap    <= pin_i;
            resnap  <= 1'b0;
            int_n_o <= 1'b1;
        end else begin
            int_n_o <= (pin_i == snap);
        end
    end
endmodule

// File: rtl/qport_i2c_slave.sv
module qport_i2c_slave
    import qport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  pin_i,
    output logic               sda_pull_o,
    output logic [BYTE_W-1:0]  latch_o,
    output logic [BYTE_W-1:0]  boost_o,
    output logic               int_n_o
);
    bus_evt_t          evt;
    logic              wr_stb;
    logic              rd_clr;
    logic [BYTE_W-1:0] wr_data;

    qport_busevt u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    qport_link u_link (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sda_i      (sda_i),
        .strap_i    (strap_i),
        .pin_i      (pin_i),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rd_clr     (rd_clr),
        .sda_pull_o (sda_pull_o)
    );

    qport_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_clr   (rd_clr),
        .scl_fall (evt.fall),
        .pin_i    (pin_i),
        .latch_o  (latch_o),
        .boost_o  (boost_o),
        .int_n_o  (int_n_o)
    );
endmodule

// File: rtl/qport_check.sv
module qport_check
    import qport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_pull_o,
    input logic [BYTE_W-1:0] latch_o,
    input logic [BYTE_W-1:0] boost_o,
    input logic              int_n_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (latch_o == '1 && boost_o == '0 && int_n_o && !sda_pull_o));

    p_pull_on_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !$past(scl_i));

    p_latch_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (latch_o != $past(latch_o)) |-> (!$past(scl_i) && $past(scl_i, 2)));

    p_boost_subset_r4: assert property (@(posedge clk) disable iff (rst)
        (boost_o & ~latch_o) == '0);

    p_boost_new_r4: assert property (@(posedge clk) disable iff (rst)
        ((boost_o & ~$past(boost_o)) != '0) |-> (latch_o != $past(latch_o)));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !sda_pull_o);
endmodule

bind qport_i2c_slave qport_check u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_pull_o (sda_pull_o),
    .latch_o    (latch_o),
    .boost_o    (boost_o),
    .int_n_o    (int_n_o)
);

// File: tb/qport_i2c_slave_test.sv
`timescale 1ns/1ps
module qport_i2c_slave_test;
    localparam logic [5:0] STRAP = 6'b101101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [7:0] ext = 8'hFF;
    logic       sda_pull;
    logic       int_n;
    logic [7:0] latch;
    logic [7:0] boost;
    logic [7:0] pins;
    logic       sda_line;

    assign sda_line = sda_drv & ~sda_pull;
    assign pins     = latch & ext;

    always #2.5 clk = ~clk;

    qport_i2c_slave uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .strap_i    (STRAP),
        .pin_i      (pins),
        .sda_pull_o (sda_pull),
        .latch_o    (latch),
        .boost_o    (boost),
        .int_n_o    (int_n)
    );

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    logic [7:0] m_latch = 8'hFF;
    logic [7:0] m_snap  = 8'hFF;

    function automatic logic [7:0] exp_boost(input logic [7:0] o, input logic [7:0] n);
        return n & ~o;
    endfunction

    function automatic logic exp_int_n(input logic [7:0] p, input logic [7:0] s);
        return p == s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; wclk(4);
        scl_drv = 1'b1; wclk(4);
        sda_drv = 1'b0; wclk(4);
        scl_drv = 1'b0; wclk(4);
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; wclk(4);
        scl_drv = 1'b1; wclk(4);
        sda_drv = 1'b1; wclk(4);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b;    wclk(4);
        scl_drv = 1'b1; wclk(8);
        scl_drv = 1'b0; wclk(4);
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; wclk(4);
        scl_drv = 1'b1; wclk(4);
        b = sda_line;   wclk(4);
        scl_drv = 1'b0; wclk(4);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic check_idle_state(input string req);
        wclk(3);
        chk(req, latch, m_latch);
        chk(req, int_n, exp_int_n(pins, m_snap));
    endtask

    // Write n bytes (LSB-first packing of data) to address byte abyte.
    task automatic wr_txn(input logic [7:0] abyte, input logic [23:0] data, input int n);
        logic ack;
        logic hit;
        logic [7:0] d;
        hit = (abyte[7:1] == {1'b0, STRAP});
        i2c_start();
        send_byte(abyte, ack);
        chk("R2 address ack", ack, hit);
        for (int i = 0; i < n; i++) begin
            d = data[8*i +: 8];
            send_byte(d, ack);
            if (hit) begin
                chk("R3 data ack", ack, 1'b1);
                chk("R3 latch", latch, d);
                chk("R4 boost", boost, exp_boost(m_latch, d));
                m_latch = d;
                m_snap  = m_latch & ext;
                wclk(1);
                chk("R8 int cleared on write", int_n, 1'b1);
            end else begin
                chk("R9 latch untouched", latch, m_latch);
            end
        end
        i2c_stop();
        chk("R10 sda released after stop", sda_pull, 1'b0);
    endtask

    task automatic rd_txn(input logic [7:0] abyte, input int n);
        logic ack;
        logic hit;
        logic [7:0] d;
        hit = (abyte[7:1] == {1'b0, STRAP});
        i2c_start();
        send_byte({abyte[7:1], 1'b1}, ack);
        chk("R2 address ack", ack, hit);
        if (hit) begin
            m_snap = m_latch & ext;
            wclk(1);
            chk("R7 int cleared on read", int_n, 1'b1);
            for (int i = 0; i < n; i++) begin
                recv_byte(i < n - 1, d);
                chk("R5 read data", d, m_latch & ext);
            end
            wclk(2);
            chk("R5 released after nack", sda_pull, 1'b0);
        end
        i2c_stop();
        chk("R10 sda released after stop", sda_pull, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] abad;
        logic [7:0] d;
        logic ack;
        void'($urandom(32'd2024));
        wclk(4);
        rst = 1'b0;
        wclk(2);
        // R1 reset state
        chk("R1 latch", latch, 8'hFF);
        chk("R1 boost", boost, 8'h00);
        chk("R1 int_n", int_n, 1'b1);
        chk("R1 sda", sda_pull, 1'b0);

        // R3/R4: two bytes in one write, then boost cleared by the next SCL fall
        wr_txn({1'b0, STRAP, 1'b0}, {8'h00, 8'hA5, 8'h00}, 2);
        chk("R4 boost held past stop", boost, exp_boost(8'h00, 8'hA5));
        i2c_start();
        chk("R4 boost off after next fall", boost, 8'h00);
        i2c_stop();
        wr_txn({1'b0, STRAP, 1'b0}, 24'h0000FF, 1);

        // R6: change and return
        ext = 8'hEF; wclk(3);
        chk("R6 int on change", int_n, 1'b0);
        ext = 8'hFF; wclk(3);
        chk("R6 int back on return", int_n, 1'b1);

        // R7: read clears, R5 multi-byte read
        ext = 8'h7E; wclk(3);
        chk("R6 int on change", int_n, 1'b0);
        rd_txn({1'b0, STRAP, 1'b1}, 3);
        check_idle_state("R7 after read");

        // R9: other addresses leave int alone
        ext = 8'h3C; wclk(3);
        chk("R6 int on change", int_n, 1'b0);
        rd_txn({1'b1, STRAP, 1'b1}, 1);
        wr_txn({1'b1, STRAP, 1'b0}, 24'h000011, 1);
        wr_txn({1'b0, STRAP ^ 6'b000100, 1'b0}, 24'h000022, 1);
        chk("R9 int still low", int_n, 1'b0);
        check_idle_state("R9 after foreign txn");

        // R8: write clears
        wr_txn({1'b0, STRAP, 1'b0}, 24'h0000F0, 1);
        check_idle_state("R8 after write");

        // R10: START in mid-byte restarts address reception
        i2c_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        i2c_start();
        send_byte({1'b0, STRAP, 1'b0}, ack);
        chk("R10 ack after restart", ack, 1'b1);
        send_byte(8'h3C, ack);
        chk("R10 latch after restart", latch, 8'h3C);
        m_latch = 8'h3C;
        m_snap  = m_latch & ext;
        i2c_stop();
        ext = 8'hFF;
        wclk(3);
        check_idle_state("R10 idle");

        // Constrained random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: begin
                    ext = 8'($urandom());
                    wclk(3);
                    chk("R6 random change", int_n, exp_int_n(pins, m_snap));
                end
                1: wr_txn({1'b0, STRAP, 1'b0}, 24'($urandom()), $urandom_range(1, 3));
                2: rd_txn({1'b0, STRAP, 1'b1}, $urandom_range(1, 2));
                default: begin
                    abad = {1'b1, 6'($urandom()), 1'b0};
                    if ($urandom_range(0, 1) == 1)
                        abad = {1'b0, STRAP ^ 6'($urandom_range(1, 63)), 1'b0};
                    d = 8'($urandom());
                    wr_txn(abad, {16'h0, d}, 1);
                    check_idle_state("R9 random foreign");
                end
            endcase
            check_idle_state("R6 random idle");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule